// File: doc/BRIEF.md
# Stereo Serial Audio Master Transceiver

This block is the clock master of a two-channel serial audio link. From the system clock it derives three outputs: an oversampling clock at 256 times the frame rate, a bit clock, and a channel-select line. It shifts a left and a right PCM sample out on a dedicated output data pin. It also collects a left and a right sample from a separate input data pin in the same frame. Because the two data pins are separate, transmit and receive run at the same time over one shared set of clocks.

The frame length is `512 * MCLK_HALF` system clocks. The oversampling clock toggles every `MCLK_HALF` system clocks. A phase accumulator spreads the `4 * SAMPLE_W` bit-clock edges of a frame evenly over it, so any sample width from 8 to 32 bits fits into the 256-tick frame. The frame rate is `f_sys / (512 * MCLK_HALF)`. For example, 24.576 MHz with `MCLK_HALF = 6` gives 8 kHz, and 98.304 MHz with `MCLK_HALF = 1` gives 192 kHz.

On the transmit side the user writes a sample pair into a holding register at any time. The block copies that register into its shifter at every frame start and pulses a request so that the next pair can be supplied. On the receive side the block delivers each captured pair together with a one-cycle valid strobe.

Top module: `i2s_master_xcvr`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the outputs hold these values: `mclk_o`=0, `bclk_o`=1, `ws_o`=1, `sdout_o`=0, `tx_req_o`=0, `rx_valid_o`=0, `rx_left_o`=0 and `rx_right_o`=0.
- R2: `mclk_o` toggles every `MCLK_HALF` system clocks, counted from reset release, so it has exactly 256 periods per frame. At each frame start it is at the same phase.
- R3: After `n` system clocks since reset, `bclk_o` has toggled `floor(n*4*SAMPLE_W / (512*MCLK_HALF))` times, starting high. Odd-numbered toggles are falling edges. This gives exactly `2*SAMPLE_W` bit-clock periods per frame.
- R4: Bit slots are numbered 0 to `2*SAMPLE_W-1` from the first falling edge of a frame. `ws_o` is 0 (left) in slots 0 to `SAMPLE_W-1` and 1 (right) in the remaining slots. It changes only in the cycle `bclk_o` falls.
- R5: `sdout_o` changes only with a falling edge of `bclk_o` and sends MSB first. Slot 1 carries the left MSB, slot `SAMPLE_W` the left LSB and slot `SAMPLE_W+1` the right MSB. Slot 0 carries the LSB of the previous frame's right sample.
- R6: At the falling edge that opens slot 0, the holding register is copied into the transmit shifter and `tx_req_o` pulses for that one cycle. If no write occurred since the previous copy, the same pair is sent again.
- R7: A write (`tx_valid_i`=1) in the same cycle as the frame-start copy does not reach the current frame. It is stored and sent in the following frame.
- R8: `sdin_i` is sampled in the cycle `bclk_o` rises, using the same slot-to-bit mapping as R5. Bits captured in slots 1 to `2*SAMPLE_W-1`, together with slot 0 of the next frame, form one pair.
- R9: `rx_valid_o` pulses for one cycle at the rising edge that captures slot 0, and only from the second frame on. `rx_left_o` and `rx_right_o` then hold the completed pair until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid_i | input | 1 | Writes the holding register with the pair below |
| tx_left_i | input | SAMPLE_W | Left sample to transmit |
| tx_right_i | input | SAMPLE_W | Right sample to transmit |
| tx_req_o | output | 1 | One-cycle pulse when a pair is taken into the shifter |
| rx_left_o | output | SAMPLE_W | Last received left sample |
| rx_right_o | output | SAMPLE_W | Last received right sample |
| rx_valid_o | output | 1 | One-cycle strobe for a completed received pair |
| mclk_o | output | 1 | Oversampling clock, 256 x frame rate |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Channel select: 0 left, 1 right |
| sdout_o | output | 1 | Serial data output |
| sdin_i | input | 1 | Serial data input |

## Verification
A user write to the holding register can land in the very cycle in which the frame start copies that register into the shifter. The bench schedules a write for exactly the system clock whose edge is the first bit-clock fall of a frame. Its reference model then expects the old pair for the frame that starts there and the new pair in the next frame, and checks every bit on the output pin against that. Frames with no write at all are also checked, to confirm that the previous pair is repeated unchanged.

// File: rtl/i2s_xcvr_pkg.sv
package i2s_xcvr_pkg;
  localparam int MCLK_RATIO = 256;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/i2s_clkgen.sv
module i2s_clkgen
  import i2s_xcvr_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int MCLK_HALF = 1,
  localparam int SLOTS    = 2 * SAMPLE_W,
  localparam int SLOT_W   = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mclk_o,
  output logic              bclk_o,
  output logic              fall_o,
  output logic              rise_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] slot_nxt_o
);
  localparam int FRAME_CYC = 2 * MCLK_RATIO * MCLK_HALF;
  localparam int STEP      = 4 * SAMPLE_W;
  localparam int ACC_W     = $clog2(FRAME_CYC) + 1;
  localparam int MC_W      = $clog2(MCLK_HALF) + 1;
  localparam int FIRST     = ceil_div(FRAME_CYC, STEP);

  logic [MC_W-1:0]   mc_cnt;
  logic              mclk_q;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  sum;
  logic              tgl;
  logic              bclk_q;
  logic [SLOT_W-1:0] slot_q;

  // oversampling clock: plain half-period counter
  always_ff @(posedge clk) begin
    if (rst) begin
      mc_cnt <= '0;
      mclk_q <= 1'b0;
    end else if (mc_cnt == MC_W'(MCLK_HALF - 1)) begin
      mc_cnt <= '0;
      mclk_q <= ~mclk_q;
    end else begin
      mc_cnt <= mc_cnt + 1'b1;
    end
  end

  // bit clock: fractional accumulator, 4*SAMPLE_W toggles per frame
  assign sum = acc + ACC_W'(STEP);
  assign tgl = (sum >= ACC_W'(FRAME_CYC));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      bclk_q <= 1'b1;
    end else if (tgl) begin
      acc    <= sum - ACC_W'(FRAME_CYC);
      bclk_q <= ~bclk_q;
    end else begin
      acc    <= sum;
    end
  end

  assign fall_o     = tgl & bclk_q;
  assign rise_o     = tgl & ~bclk_q;
  assign slot_nxt_o = (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)         slot_q <= SLOT_W'(SLOTS - 1);
    else if (fall_o) slot_q <= slot_nxt_o;
  end

  assign mclk_o = mclk_q;
  assign bclk_o = bclk_q;
  assign slot_o = slot_q;

  // R2: every frame opens at the same oversampling clock phase
  assert_mclk_frame_phase_R2: assert property (@(posedge clk) disable iff (rst)
    (fall_o && slot_nxt_o == '0) |=>
      (mc_cnt == MC_W'(FIRST % MCLK_HALF) && mclk_q == 1'((FIRST / MCLK_HALF) % 2)));

  // R3: no two bit-clock toggles in adjacent cycles
  assert_bclk_no_glitch_R3: assert property (@(posedge clk) disable iff (rst)
    tgl |=> !tgl);
endmodule

// File: rtl/i2s_tx_ser.sv
module i2s_tx_ser #(
  parameter int SAMPLE_W = 24,
  localparam int SLOTS   = 2 * SAMPLE_W,
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fall_i,
  input  logic [SLOT_W-1:0]   slot_nxt_i,
  input  logic                tx_valid_i,
  input  logic [SAMPLE_W-1:0] tx_left_i,
  input  logic [SAMPLE_W-1:0] tx_right_i,
  output logic                ws_o,
  output logic                sdout_o,
  output logic                tx_req_o
);
  logic [SAMPLE_W-1:0] hold_l, hold_r;
  logic [SLOTS-1:0]    shreg;
  logic                ws_q, sd_q, req_q;

  // holding register; the frame-start copy below sees the old value
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_l <= '0;
      hold_r <= '0;
    end else if (tx_valid_i) begin
      hold_l <= tx_left_i;
      hold_r <= tx_right_i;
    end
  end

  // slot 0 emits the top bit left after 2W-1 shifts: previous right LSB
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      ws_q  <= 1'b1;
      sd_q  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (fall_i) begin
        sd_q <= shreg[SLOTS-1];
        ws_q <= (slot_nxt_i >= SLOT_W'(SAMPLE_W));
        if (slot_nxt_i == '0) begin
          shreg <= {hold_l, hold_r};
          req_q <= 1'b1;
        end else begin
          shreg <= {shreg[SLOTS-2:0], 1'b0};
        end
      end
    end
  end

  assign ws_o     = ws_q;
  assign sdout_o  = sd_q;
  assign tx_req_o = req_q;

  // R4: channel select moves only with a bit-clock fall
  assert_ws_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (ws_q != $past(ws_q)) |-> $past(fall_i));

  // R5: output data moves only with a bit-clock fall
  assert_sdout_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (sd_q != $past(sd_q)) |-> $past(fall_i));

  // R6: the request marks the start of the left half
  assert_req_at_left_start_R6: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (!ws_q && $past(ws_q)));
endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser #(
  parameter int SAMPLE_W = 24,
  localparam int SLOTS   = 2 * SAMPLE_W,
  localparam int SLOT_W  = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rise_i,
  input  logic [SLOT_W-1:0]   slot_i,
  input  logic                sdin_i,
  output logic [SAMPLE_W-1:0] rx_left_o,
  output logic [SAMPLE_W-1:0] rx_right_o,
  output logic                rx_valid_o
);
  logic [SLOTS-2:0]    rsh;
  logic [SLOTS-1:0]    full;
  logic                primed;
  logic [SAMPLE_W-1:0] l_q, r_q;
  logic                v_q;

  assign full = {rsh, sdin_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsh    <= '0;
      primed <= 1'b0;
      l_q    <= '0;
      r_q    <= '0;
      v_q    <= 1'b0;
    end else begin
      v_q <= 1'b0;
      if (rise_i) begin
        rsh <= full[SLOTS-2:0];
        if (slot_i == '0) begin
          if (primed) begin
            l_q <= full[SLOTS-1:SAMPLE_W];
            r_q <= full[SAMPLE_W-1:0];
            v_q <= 1'b1;
          end
        end else begin
          primed <= 1'b1;
        end
      end
    end
  end

  assign rx_left_o  = l_q;
  assign rx_right_o = r_q;
  assign rx_valid_o = v_q;

  // R9: strobe lasts one cycle
  assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst)
    v_q |=> !v_q);

  // R9: received data changes only together with the strobe
  assert_data_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !v_q |-> (l_q == $past(l_q) && r_q == $past(r_q)));
endmodule

// File: rtl/i2s_master_xcvr.sv
module i2s_master_xcvr #(
  parameter int SAMPLE_W  = 24,
  parameter int MCLK_HALF = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tx_valid_i,
  input  logic [SAMPLE_W-1:0] tx_left_i,
  input  logic [SAMPLE_W-1:0] tx_right_i,
  output logic                tx_req_o,
  output logic [SAMPLE_W-1:0] rx_left_o,
  output logic [SAMPLE_W-1:0] rx_right_o,
  output logic                rx_valid_o,
  output logic                mclk_o,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sdout_o,
  input  logic                sdin_i
);
  localparam int SLOT_W = $clog2(2 * SAMPLE_W);

  logic              fall, rise;
  logic [SLOT_W-1:0] slot, slot_nxt;

  i2s_clkgen #(.SAMPLE_W(SAMPLE_W), .MCLK_HALF(MCLK_HALF)) u_clkgen (
    .clk        (clk),
    .rst        (rst),
    .mclk_o     (mclk_o),
    .bclk_o     (bclk_o),
    .fall_o     (fall),
    .rise_o     (rise),
    .slot_o     (slot),
    .slot_nxt_o (slot_nxt)
  );

  i2s_tx_ser #(.SAMPLE_W(SAMPLE_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .fall_i     (fall),
    .slot_nxt_i (slot_nxt),
    .tx_valid_i (tx_valid_i),
    .tx_left_i  (tx_left_i),
    .tx_right_i (tx_right_i),
    .ws_o       (ws_o),
    .sdout_o    (sdout_o),
    .tx_req_o   (tx_req_o)
  );

  i2s_rx_deser #(.SAMPLE_W(SAMPLE_W)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .rise_i     (rise),
    .slot_i     (slot),
    .sdin_i     (sdin_i),
    .rx_left_o  (rx_left_o),
    .rx_right_o (rx_right_o),
    .rx_valid_o (rx_valid_o)
  );

  // R9: a received pair is completed on a bit-clock rise, in the left half
  assert_valid_on_rise_R9: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |-> (bclk_o && !$past(bclk_o) && !ws_o));

  // R4: channel select and bit clock fall together
  assert_ws_fall_with_bclk_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ws_o) |-> $fell(bclk_o));
endmodule

// File: tb/test_i2s_master_xcvr.sv
module test_i2s_master_xcvr;
  localparam int W      = 24;
  localparam int H      = 1;
  localparam int FRM    = 512 * H;
  localparam int STEP   = 4 * W;
  localparam int FIRSTE = (FRM + STEP - 1) / STEP;
  localparam int FRAMES = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tx_valid = 1'b0;
  logic [W-1:0] tx_l = '0, tx_r = '0;
  logic         sdin = 1'b0;
  logic         tx_req, rx_valid, mclk, bclk, ws, sdout;
  logic [W-1:0] rx_l, rx_r;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  i2s_master_xcvr #(.SAMPLE_W(W), .MCLK_HALF(H)) i_i2s_master_xcvr (
    .clk(clk), .rst(rst),
    .tx_valid_i(tx_valid), .tx_left_i(tx_l), .tx_right_i(tx_r),
    .tx_req_o(tx_req), .rx_left_o(rx_l), .rx_right_o(rx_r), .rx_valid_o(rx_valid),
    .mclk_o(mclk), .bclk_o(bclk), .ws_o(ws), .sdout_o(sdout), .sdin_i(sdin)
  );

  function automatic logic [W-1:0] mix(input int x);
    int unsigned v;
    v = (x + 7) * 32'h9E3779B1;
    v = v ^ (v >> 13) ^ 32'h00A5C3;
    return v[W-1:0];
  endfunction

  // bit carried in slot k: 0 -> previous right LSB, 1..W -> left MSB first, rest -> right
  function automatic logic bitof(input int k, input logic [W-1:0] l, r, pr);
    if (k == 0) return pr[0];
    if (k <= W) return l[W-k];
    return r[2*W-k];
  endfunction

  // ---------------- reference model ----------------
  int           n;
  int           frame;
  int           m_slot;
  logic         e_mclk, e_bclk, e_ws, e_sd, e_txreq, e_rxv;
  logic [W-1:0] e_rxl, e_rxr;
  logic [W-1:0] hold_l, hold_r, cur_l, cur_r, prev_r;
  logic [W-1:0] src_l, src_r, srcp_l, srcp_r;
  logic         wrote;
  string        sd_tag;

  always @(posedge clk) begin
    if (rst) begin
      n = 0; frame = -1; m_slot = 2*W-1;
      e_mclk = 0; e_bclk = 1; e_ws = 1; e_sd = 0; e_txreq = 0; e_rxv = 0;
      e_rxl = '0; e_rxr = '0;
      hold_l = '0; hold_r = '0; cur_l = '0; cur_r = '0; prev_r = '0;
      src_l = '0; src_r = '0; srcp_l = '0; srcp_r = '0;
      wrote = 0; sd_tag = "R5";
    end else begin
      longint h, h0;
      n++;
      e_mclk  = 1'((n / H) % 2);
      e_txreq = 0;
      e_rxv   = 0;
      h  = (longint'(n) * STEP) / FRM;
      h0 = (longint'(n - 1) * STEP) / FRM;
      if (h != h0) begin
        int tf, k;
        tf = int'((h - 1) % (4*W));
        k  = tf / 2;
        if (tf % 2 == 0) begin
          e_bclk = 0;
          m_slot = k;
          if (k == 0) begin
            prev_r = cur_r; cur_l = hold_l; cur_r = hold_r;
            e_txreq = 1;
            sd_tag = tx_valid ? "R7" : (wrote ? "R5" : "R6");
            wrote = 0;
            frame++;
            srcp_l = src_l; srcp_r = src_r;
            src_l = mix(3*frame + 1); src_r = mix(5*frame + 2);
          end
          e_ws = (k >= W);
          e_sd = bitof(k, cur_l, cur_r, prev_r);
        end else begin
          e_bclk = 1;
          if (k == 0 && frame >= 1) begin
            e_rxv = 1; e_rxl = srcp_l; e_rxr = srcp_r;
          end
        end
      end
      if (tx_valid) begin
        hold_l = tx_l; hold_r = tx_r; wrote = 1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, n, act, exp);
    end
  endtask

  // ---------------- stimulus and comparison ----------------
  initial begin
    repeat (4) @(negedge clk);
    // R1: values held during reset
    chk("R1", "mclk", mclk, 0);
    chk("R1", "bclk", bclk, 1);
    chk("R1", "ws", ws, 1);
    chk("R1", "sdout", sdout, 0);
    chk("R1", "tx_req", tx_req, 0);
    chk("R1", "rx_valid", rx_valid, 0);
    chk("R1", "rx_left", rx_l, 0);
    chk("R1", "rx_right", rx_r, 0);
    rst = 1'b0;
    while (n < FRAMES * FRM + 2*FIRSTE) begin
      int p, m;
      @(negedge clk);
      chk("R2", "mclk", mclk, e_mclk);
      chk("R3", "bclk", bclk, e_bclk);
      chk("R4", "ws", ws, e_ws);
      chk(sd_tag, "sdout", sdout, e_sd);
      chk("R6", "tx_req", tx_req, e_txreq);
      chk("R9", "rx_valid", rx_valid, e_rxv);
      chk("R8", "rx_left", rx_l, e_rxl);
      chk("R8", "rx_right", rx_r, e_rxr);
      // next capture edge is n+1
      p = (n + 1) % FRM;
      m = (n + 1) / FRM;
      tx_valid = ((m % 4 == 0) && p == 100) ||
                 ((m % 4 == 1) && (p == 50 || p == 300)) ||
                 ((m % 4 == 2) && p == FIRSTE);   // R7 collision with frame-start copy
      tx_l = mix(n + 1000);
      tx_r = mix(n + 2000);
      sdin = bitof(m_slot, src_l, src_r, srcp_r);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule